// File: doc/BRIEF.md
# Stop-State Clock Power Controller

This controller sits beside a processor's clock generator and decides which clock resources keep running while the core is halted by a stop instruction. On a stop request it closes the clock gate that feeds the output divider and the core. It also decides whether the reference oscillator and the phase-locked loop stay powered. That choice depends on a keep-alive setting, the loop enable and the oscillator disable. All four configuration inputs, including the recovery-length select, are captured at the moment the stop is accepted.

On a wake event the controller times the recovery and then releases the core through its ready output. Two paths exist. If the oscillator and loop were kept alive, the restart is short and fixed. If they were shut down, the oscillator is restarted and given a settle count of either 16 or 65536 reference cycles, chosen by the long-wait select. When the loop is enabled, the controller then waits for the lock-detected input before it releases the core.

All pins are plain level controls and status. No data stream passes through the block, so there is no handshake at its edge.

Top module: `stop_clk_ctrl`

## Requirements
- R1: After reset the controller is running: `core_ready`=1, `core_clk_en`=1, `osc_en` = NOT `osc_dis`, and `loop_on` = `loop_en`.
- R2: A `stop_req` high at a clock edge while running drops `core_ready` and `core_clk_en` after that edge. `keep_alive`, `loop_en`, `osc_dis` and `long_wait` are captured at that edge, and changes to them have no effect on the outputs until `core_ready` is high again.
- R3: With `keep_alive`=0 captured, `osc_en`=0 and `loop_on`=0 while stopped, whatever `loop_en` is.
- R4: With `keep_alive`=1 and `loop_en`=0 captured, `loop_on`=0 and `osc_en`=1 (given `osc_dis`=0) while stopped.
- R5: With `keep_alive`=1 and `loop_en`=1 captured, `osc_en`=1 and `loop_on`=1 while stopped.
- R6: With `keep_alive`=1 and `osc_dis`=1 captured, `osc_en`=0 while stopped; only the core clock gate otherwise changes.
- R7: After a keep-alive stop, `core_ready` rises at exactly the third clock edge after the edge that samples `wake` high.
- R8: After a stop with `keep_alive`=0 and `loop_en`=0, `core_ready` rises exactly 16 edges after the wake edge when `long_wait`=0, and exactly 65536 edges after it when `long_wait`=1.
- R9: After a stop with `keep_alive`=0 and `loop_en`=1, once the settle count ends the controller waits for `lock_det`. `core_ready` rises at the first edge that samples `lock_det` high.
- R10: `wake` is ignored while running or recovering, and `stop_req` is ignored unless `core_ready` is high. Neither changes the recovery time or the outputs.
- R11: The 17-bit recovery counter clears on stop entry, so repeated stops with the same settings give the same recovery time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| keep_alive | input | 1 | Keep oscillator (and loop) running during stop |
| loop_en | input | 1 | Phase-locked loop enabled |
| osc_dis | input | 1 | Oscillator disabled |
| stop_req | input | 1 | Stop instruction executed |
| wake | input | 1 | Wake event |
| long_wait | input | 1 | 1 selects the 65536-cycle settle count, 0 selects 16 |
| lock_det | input | 1 | Loop lock detected |
| osc_en | output | 1 | Oscillator enable |
| loop_on | output | 1 | Loop enable |
| core_clk_en | output | 1 | Clock gate for the divider and the core |
| core_ready | output | 1 | Core released |

## Verification
On every cycle, the embedded properties check four things. The resource outputs are off during a full shutdown. The captured configuration holds steady while the core is held. A short restart always follows three restart cycles, and release after lock waiting follows a sampled lock. The recovery counter never passes its limit while the settle window is still open. Only the bench scenarios can show the end-to-end recovery latencies: 3, 16, 65536, and the lock-dependent delay. They also show that wake and stop pulses arriving mid-recovery leave those latencies unchanged, and that each keep-alive combination gives the right oscillator and loop levels at the ports.

// File: rtl/stop_clk_pkg.sv
package stop_clk_pkg;
  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_STOPPED    = 3'd1,
    ST_OSC_SETTLE = 3'd2,
    ST_WAIT_LOCK  = 3'd3,
    ST_RESTART    = 3'd4
  } stop_state_e;

  typedef struct packed {
    logic keep;
    logic loop;
    logic osc_off;
    logic long_wait;
  } stop_cfg_t;
endpackage

// File: rtl/stop_cfg_hold.sv
module stop_cfg_hold
  import stop_clk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      capture,
  input  stop_cfg_t cfg_in,
  output stop_cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (capture) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/stop_rec_timer.sv
module stop_rec_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (run)   cnt <= done ? '0 : cnt + 1'b1;
  end

  // R8: the counter never runs past the selected limit
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit));
endmodule

// File: rtl/stop_clk_ctrl.sv
module stop_clk_ctrl
  import stop_clk_pkg::*;
#(
  parameter int CNT_W       = 17,
  parameter int SHORT_SETTLE = 16,
  parameter int LONG_SETTLE  = 65536,
  parameter int RESTART_CYC  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic keep_alive,
  input  logic loop_en,
  input  logic osc_dis,
  input  logic stop_req,
  input  logic wake,
  input  logic long_wait,
  input  logic lock_det,
  output logic osc_en,
  output logic loop_on,
  output logic core_clk_en,
  output logic core_ready
);
  localparam logic [CNT_W-1:0] LIM_SHORT   = CNT_W'(SHORT_SETTLE - 1);
  localparam logic [CNT_W-1:0] LIM_LONG    = CNT_W'(LONG_SETTLE - 1);
  localparam logic [CNT_W-1:0] LIM_RESTART = CNT_W'(RESTART_CYC - 1);

  stop_state_e state, state_nx;
  stop_cfg_t   cfg_in, cfg_q;
  logic        capture, tmr_clr, tmr_run, tmr_done;
  logic [CNT_W-1:0] tmr_limit;

  assign cfg_in  = '{keep: keep_alive, loop: loop_en, osc_off: osc_dis, long_wait: long_wait};
  assign capture = (state == ST_RUN) && stop_req;

  stop_cfg_hold u_cfg (
    .clk(clk), .rst_n(rst_n), .capture(capture), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  assign tmr_clr   = (state == ST_RUN) || (state == ST_STOPPED);
  assign tmr_run   = (state == ST_RESTART) || (state == ST_OSC_SETTLE);
  assign tmr_limit = (state == ST_RESTART) ? LIM_RESTART :
                     (cfg_q.long_wait ? LIM_LONG : LIM_SHORT);

  stop_rec_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run),
    .limit(tmr_limit), .done(tmr_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:        if (stop_req) state_nx = ST_STOPPED;
      ST_STOPPED:    if (wake) state_nx = cfg_q.keep ? ST_RESTART : ST_OSC_SETTLE;
      ST_RESTART:    if (tmr_done) state_nx = ST_RUN;
      ST_OSC_SETTLE: if (tmr_done) state_nx = cfg_q.loop ? ST_WAIT_LOCK : ST_RUN;
      ST_WAIT_LOCK:  if (lock_det) state_nx = ST_RUN;
      default:       state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= state_nx;
  end

  always_comb begin
    core_ready  = 1'b0;
    core_clk_en = 1'b0;
    osc_en      = 1'b0;
    loop_on     = 1'b0;
    unique case (state)
      ST_RUN: begin
        core_ready  = 1'b1;
        core_clk_en = 1'b1;
        osc_en      = !osc_dis;
        loop_on     = loop_en;
      end
      ST_STOPPED, ST_RESTART: begin
        osc_en  = cfg_q.keep && !cfg_q.osc_off;
        loop_on = cfg_q.keep && cfg_q.loop;
      end
      ST_OSC_SETTLE, ST_WAIT_LOCK: begin
        osc_en  = !cfg_q.osc_off;
        loop_on = cfg_q.loop;
      end
      default: ;
    endcase
  end

  // R3: full shutdown keeps oscillator and loop off
  assert_shutdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOPPED && !cfg_q.keep) |-> (!osc_en && !loop_on));

  // R2: captured settings hold while the core is held
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_ready && $past(!core_ready)) |-> $stable(cfg_q));

  // R7: a short restart always spans three restart cycles
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(core_ready) && $past(state) == ST_RESTART) |->
      ($past(state, 3) == ST_RESTART && $past(state, 4) == ST_STOPPED));

  // R9: release from lock waiting follows a sampled lock
  assert_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_WAIT_LOCK && state == ST_RUN) |-> $past(lock_det));

  // R10: an open settle window is not cut short by other inputs
  assert_settle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OSC_SETTLE && !tmr_done) |=> (state == ST_OSC_SETTLE));
endmodule

// File: tb/sim_stop_clk_ctrl.sv
`timescale 1ns/1ps
module sim_stop_clk_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic keep_alive = 1'b0, loop_en = 1'b0, osc_dis = 1'b0;
  logic stop_req = 1'b0, wake = 1'b0, long_wait = 1'b0, lock_det = 1'b0;
  logic osc_en, loop_on, core_clk_en, core_ready;

  int tests = 0;
  int fails = 0;
  int mon_done = 0;
  int exp_q[$];
  string tag_q[$];
  event wake_ev;

  always #4 clk = ~clk;

  stop_clk_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .keep_alive(keep_alive), .loop_en(loop_en),
    .osc_dis(osc_dis), .stop_req(stop_req), .wake(wake), .long_wait(long_wait),
    .lock_det(lock_det), .osc_en(osc_en), .loop_on(loop_on),
    .core_clk_en(core_clk_en), .core_ready(core_ready)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // scoreboard monitor: measures wake-to-ready edges and pops the expectation
  initial begin
    forever begin
      int n;
      int e;
      string t;
      @(wake_ev);
      n = 0;
      while (!core_ready && n < 70000) begin
        @(negedge clk);
        n++;
      end
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (n != e) begin
        fails++;
        $display("FAIL %s: latency %0d expected %0d", t, n, e);
      end
      mon_done++;
    end
  end

  task automatic do_stop();
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
  endtask

  // driver: pushes expected latency, sends wake, optional noise and lock
  task automatic do_wake(input int exp, input string tag, input bit noise, input int lock_at);
    int d;
    int target;
    target = mon_done + 1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk) wake = 1'b1;
    @(negedge clk) wake = 1'b0;
    -> wake_ev;
    d = 0;
    if (noise) begin
      @(negedge clk) begin wake = 1'b1; stop_req = 1'b1; end
      @(negedge clk) begin wake = 1'b0; stop_req = 1'b0; end
      d = 2;
    end
    if (lock_at > 0) begin
      while (d < lock_at) begin
        @(negedge clk);
        d++;
      end
      lock_det = 1'b1;
    end
    wait (mon_done == target);
    @(negedge clk) lock_det = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(core_ready, 1'b1, "R1 ready");
    check(core_clk_en, 1'b1, "R1 gate");
    check(osc_en, 1'b1, "R1 osc");
    check(loop_on, 1'b0, "R1 loop");

    // keep-alive with loop: both stay on, config captured
    keep_alive = 1'b1; loop_en = 1'b1;
    do_stop();
    check(core_ready, 1'b0, "R2 ready low");
    check(core_clk_en, 1'b0, "R2 gate low");
    check(osc_en, 1'b1, "R5 osc");
    check(loop_on, 1'b1, "R5 loop");
    loop_en = 1'b0;
    @(negedge clk);
    check(loop_on, 1'b1, "R2 config held");
    do_wake(3, "R7 restart", 1'b0, 0);
    check(core_clk_en, 1'b1, "R7 gate reopened");

    // keep-alive without loop, with stray stop/wake during restart
    do_stop();
    check(osc_en, 1'b1, "R4 osc");
    check(loop_on, 1'b0, "R4 loop");
    do_wake(3, "R10 restart with noise", 1'b1, 0);
    @(negedge clk);
    check(core_ready, 1'b1, "R10 stop during recovery ignored");

    // keep-alive with oscillator disabled
    osc_dis = 1'b1;
    do_stop();
    check(osc_en, 1'b0, "R6 osc off");
    check(core_clk_en, 1'b0, "R6 gate");
    do_wake(3, "R6 restart", 1'b0, 0);
    osc_dis = 1'b0;

    // wake while running is ignored
    @(negedge clk) wake = 1'b1;
    @(negedge clk) wake = 1'b0;
    check(core_ready, 1'b1, "R10 wake in run");

    // full shutdown with loop: settle 16 then wait for lock at 21
    keep_alive = 1'b0; loop_en = 1'b1;
    do_stop();
    check(osc_en, 1'b0, "R3 osc");
    check(loop_on, 1'b0, "R3 loop");
    do_wake(21, "R9 lock wait", 1'b1, 20);

    // full shutdown without loop, short settle, twice
    loop_en = 1'b0;
    do_stop();
    do_wake(16, "R8 short settle", 1'b0, 0);
    do_stop();
    do_wake(16, "R11 repeat settle", 1'b0, 0);

    // long settle
    long_wait = 1'b1;
    do_stop();
    do_wake(65536, "R8 long settle", 1'b0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule